// File: doc/BRIEF.md
# Per-Process Segment Translation Unit

This block turns a virtual reference, given as a process identifier, a segment number and an offset, into a physical address. Each process has a private table of segment entries, and each entry holds a physical base, a segment length and a residency flag. Because each process has its own table, two processes can reach the same physical region through different segment numbers. Every reference is checked for residency and for bounds. A reference returns exactly one verdict: a translated address, a missing-segment fault or a bounds fault.

The kernel maintains the tables through a write port with three independent field enables: base, length and residency. A swapped-in segment can therefore be moved to a new base, or a segment resized, without touching the other fields. The entry is read when the request is captured. A write to the same entry in that cycle only affects later lookups.

A two-state controller sequences the response. `ST_IDLE` means no response is pending. `ST_CHECK` means a captured request is being answered this cycle. The transitions are as follows. IDLE goes to CHECK on an accepted request, and stays in IDLE otherwise. CHECK goes to CHECK when another request arrives back to back, and goes to IDLE otherwise.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, rsp_valid, rsp_ok, rsp_miss and rsp_bounds are low and rsp_paddr is zero. Every entry of every process is non-resident, so a first lookup reports rsp_miss.
- R2: A request sampled with req_valid high at a rising edge produces rsp_valid high for exactly the following cycle. With req_valid low, rsp_valid is low in the following cycle.
- R3: For a resident entry with offset below length, rsp_ok is high and rsp_paddr equals base plus offset, modulo 2^PA_W (16 bits by default).
- R4: A non-resident entry raises rsp_miss with rsp_paddr zero, whatever the offset and length.
- R5: An offset greater than or equal to the entry length raises rsp_bounds with rsp_paddr zero. An offset of length minus one translates normally, and a length of zero faults every offset.
- R6: While rsp_valid is high, exactly one of rsp_ok, rsp_miss and rsp_bounds is high. While rsp_valid is low, all three are low.
- R7: Each process has its own table. The same segment number in two processes selects different entries, and entries of different processes may share a base.
- R8: A write with only wr_base_en high changes that entry's base and leaves its length and residency unchanged.
- R9: A write with only wr_len_en high changes that entry's length and leaves its base and residency unchanged.
- R10: A table write in the same cycle as a lookup of the same entry is not seen by that lookup. It is seen by the next one.
- R11: A write with only wr_pres_en high sets or clears residency and leaves base and length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_pid | input | 2 | Process identifier of the request |
| req_seg | input | 2 | Segment number of the request |
| req_off | input | 12 | Offset within the segment |
| wr_pid | input | 2 | Process identifier of the table write |
| wr_seg | input | 2 | Segment number of the table write |
| wr_base_en | input | 1 | Write the base field |
| wr_base | input | 16 | New base |
| wr_len_en | input | 1 | Write the length field |
| wr_len | input | 13 | New length |
| wr_pres_en | input | 1 | Write the residency flag |
| wr_pres | input | 1 | New residency flag |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | Segment not resident |
| rsp_bounds | output | 1 | Offset outside the segment |
| rsp_paddr | output | 16 | Physical address, zero unless rsp_ok |

## Verification
Two properties are checked on every cycle. The response must follow each request by exactly one cycle. Each response must carry exactly one verdict and a zero address on a fault. Checking arithmetic correctness of the address needs the bench's scenarios, because the outputs alone do not show it. The same holds for per-process isolation, the sharing of a base by two processes, and the independence of the field writes. So too for the rule that a same-cycle write is invisible to the current lookup, and for the precedence of residency over bounds.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_CHECK = 1'b1
    } xl_state_e;

    typedef enum logic [1:0] {
        VERD_OK     = 2'd0,
        VERD_MISS   = 2'd1,
        VERD_BOUNDS = 2'd2
    } verdict_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int NUM_PROC = 4,
    parameter int NUM_SEG  = 4,
    parameter int PA_W     = 16,
    parameter int LEN_W    = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_PROC)-1:0] wr_pid,
    input  logic [$clog2(NUM_SEG)-1:0]  wr_seg,
    input  logic                        wr_base_en,
    input  logic [PA_W-1:0]             wr_base,
    input  logic                        wr_len_en,
    input  logic [LEN_W-1:0]            wr_len,
    input  logic                        wr_pres_en,
    input  logic                        wr_pres,
    input  logic [$clog2(NUM_PROC)-1:0] rd_pid,
    input  logic [$clog2(NUM_SEG)-1:0]  rd_seg,
    output logic [PA_W-1:0]             rd_base,
    output logic [LEN_W-1:0]            rd_len,
    output logic                        rd_pres
);
    localparam int PID_W   = $clog2(NUM_PROC);
    localparam int SEG_W   = $clog2(NUM_SEG);
    localparam int IDX_W   = PID_W + SEG_W;
    localparam int ENTRIES = NUM_PROC * NUM_SEG;

    logic [PA_W-1:0]  base_q [ENTRIES];
    logic [LEN_W-1:0] len_q  [ENTRIES];
    logic             pres_q [ENTRIES];

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign wr_idx = {wr_pid, wr_seg};
    assign rd_idx = {rd_pid, rd_seg};

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic hit;
        assign hit = (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[e] <= '0;
            end else if (hit && wr_base_en) begin
                base_q[e] <= wr_base;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                len_q[e] <= '0;
            end else if (hit && wr_len_en) begin
                len_q[e] <= wr_len;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pres_q[e] <= 1'b0;
            end else if (hit && wr_pres_en) begin
                pres_q[e] <= wr_pres;
            end
        end
    end

    always_comb begin
        rd_base = base_q[rd_idx];
        rd_len  = len_q[rd_idx];
        rd_pres = pres_q[rd_idx];
    end
endmodule

// File: rtl/seg_req_stage.sv
module seg_req_stage #(
    parameter int OFF_W = 12,
    parameter int PA_W  = 16,
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [OFF_W-1:0] in_off,
    input  logic [PA_W-1:0]  in_base,
    input  logic [LEN_W-1:0] in_len,
    input  logic             in_pres,
    output logic [OFF_W-1:0] q_off,
    output logic [PA_W-1:0]  q_base,
    output logic [LEN_W-1:0] q_len,
    output logic             q_pres
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_off  <= '0;
            q_base <= '0;
            q_len  <= '0;
            q_pres <= 1'b0;
        end else if (capture) begin
            q_off  <= in_off;
            q_base <= in_base;
            q_len  <= in_len;
            q_pres <= in_pres;
        end
    end
endmodule

// File: rtl/seg_check.sv
module seg_check
    import segxl_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int PA_W  = 16,
    parameter int LEN_W = 13
) (
    input  logic [OFF_W-1:0] off,
    input  logic [PA_W-1:0]  base,
    input  logic [LEN_W-1:0] len,
    input  logic             pres,
    output verdict_e         verdict,
    output logic [PA_W-1:0]  sum
);
    logic in_range;

    assign in_range = (LEN_W'(off) < len);
    assign sum      = base + PA_W'(off);

    always_comb begin
        if (!pres) begin
            verdict = VERD_MISS;
        end else if (!in_range) begin
            verdict = VERD_BOUNDS;
        end else begin
            verdict = VERD_OK;
        end
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import segxl_pkg::*;
#(
    parameter int NUM_PROC = 4,
    parameter int NUM_SEG  = 4,
    parameter int OFF_W    = 12,
    parameter int PA_W     = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [$clog2(NUM_PROC)-1:0] req_pid,
    input  logic [$clog2(NUM_SEG)-1:0]  req_seg,
    input  logic [OFF_W-1:0]            req_off,
    input  logic [$clog2(NUM_PROC)-1:0] wr_pid,
    input  logic [$clog2(NUM_SEG)-1:0]  wr_seg,
    input  logic                        wr_base_en,
    input  logic [PA_W-1:0]             wr_base,
    input  logic                        wr_len_en,
    input  logic [OFF_W:0]              wr_len,
    input  logic                        wr_pres_en,
    input  logic                        wr_pres,
    output logic                        rsp_valid,
    output logic                        rsp_ok,
    output logic                        rsp_miss,
    output logic                        rsp_bounds,
    output logic [PA_W-1:0]             rsp_paddr
);
    localparam int LEN_W = OFF_W + 1;

    xl_state_e state_q, state_d;

    logic [PA_W-1:0]  tbl_base;
    logic [LEN_W-1:0] tbl_len;
    logic             tbl_pres;

    logic [OFF_W-1:0] cap_off;
    logic [PA_W-1:0]  cap_base;
    logic [LEN_W-1:0] cap_len;
    logic             cap_pres;

    verdict_e         verdict;
    logic [PA_W-1:0]  sum;

    seg_table #(
        .NUM_PROC (NUM_PROC),
        .NUM_SEG  (NUM_SEG),
        .PA_W     (PA_W),
        .LEN_W    (LEN_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_pid     (wr_pid),
        .wr_seg     (wr_seg),
        .wr_base_en (wr_base_en),
        .wr_base    (wr_base),
        .wr_len_en  (wr_len_en),
        .wr_len     (wr_len),
        .wr_pres_en (wr_pres_en),
        .wr_pres    (wr_pres),
        .rd_pid     (req_pid),
        .rd_seg     (req_seg),
        .rd_base    (tbl_base),
        .rd_len     (tbl_len),
        .rd_pres    (tbl_pres)
    );

    seg_req_stage #(
        .OFF_W (OFF_W),
        .PA_W  (PA_W),
        .LEN_W (LEN_W)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (req_valid),
        .in_off  (req_off),
        .in_base (tbl_base),
        .in_len  (tbl_len),
        .in_pres (tbl_pres),
        .q_off   (cap_off),
        .q_base  (cap_base),
        .q_len   (cap_len),
        .q_pres  (cap_pres)
    );

    seg_check #(
        .OFF_W (OFF_W),
        .PA_W  (PA_W),
        .LEN_W (LEN_W)
    ) u_check (
        .off     (cap_off),
        .base    (cap_base),
        .len     (cap_len),
        .pres    (cap_pres),
        .verdict (verdict),
        .sum     (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_CHECK : ST_IDLE;
            ST_CHECK: state_d = req_valid ? ST_CHECK : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rsp_valid  = 1'b0;
        rsp_ok     = 1'b0;
        rsp_miss   = 1'b0;
        rsp_bounds = 1'b0;
        rsp_paddr  = '0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
            end
            ST_CHECK: begin
                rsp_valid  = 1'b1;
                rsp_ok     = (verdict == VERD_OK);
                rsp_miss   = (verdict == VERD_MISS);
                rsp_bounds = (verdict == VERD_BOUNDS);
                rsp_paddr  = (verdict == VERD_OK) ? sum : '0;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int PA_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            rsp_valid,
    input logic            rsp_ok,
    input logic            rsp_miss,
    input logic            rsp_bounds,
    input logic [PA_W-1:0] rsp_paddr
);
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_req_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_single_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_ok, rsp_miss, rsp_bounds}) == 1));

    p_quiet_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($countones({rsp_ok, rsp_miss, rsp_bounds}) == 0));

    // R4 and R5: a faulting response never carries an address
    p_fault_zero_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss || rsp_bounds) |-> (rsp_paddr == '0));
endmodule

bind seg_xlate_unit seg_xlate_chk #(.PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .rsp_miss   (rsp_miss),
    .rsp_bounds (rsp_bounds),
    .rsp_paddr  (rsp_paddr)
);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;
    localparam int K_OK = 0, K_MISS = 1, K_BND = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_pid = '0, req_seg = '0;
    logic [11:0] req_off = '0;
    logic [1:0]  wr_pid = '0, wr_seg = '0;
    logic        wr_base_en = 1'b0, wr_len_en = 1'b0, wr_pres_en = 1'b0, wr_pres = 1'b0;
    logic [15:0] wr_base = '0;
    logic [12:0] wr_len = '0;
    logic        rsp_valid, rsp_ok, rsp_miss, rsp_bounds;
    logic [15:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    seg_xlate_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pid(req_pid),
        .req_seg(req_seg), .req_off(req_off), .wr_pid(wr_pid), .wr_seg(wr_seg),
        .wr_base_en(wr_base_en), .wr_base(wr_base), .wr_len_en(wr_len_en),
        .wr_len(wr_len), .wr_pres_en(wr_pres_en), .wr_pres(wr_pres),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_miss(rsp_miss),
        .rsp_bounds(rsp_bounds), .rsp_paddr(rsp_paddr)
    );

    task automatic expect_rsp(string tag, bit ev, int kind, logic [15:0] epa);
        logic [4:0] act, exp;
        act = {rsp_valid, rsp_ok, rsp_miss, rsp_bounds, 1'b0};
        exp = {ev, ev && kind == K_OK, ev && kind == K_MISS, ev && kind == K_BND, 1'b0};
        checks++;
        if (act !== exp || rsp_paddr !== epa) begin
            errors++;
            $display("FAIL %s: flags(v,ok,miss,bnd)=%b paddr=%0d expected flags=%b paddr=%0d",
                     tag, act[4:1], rsp_paddr, exp[4:1], epa);
        end
    endtask

    task automatic put(logic [1:0] p, logic [1:0] s, bit be, logic [15:0] b,
                       bit le, logic [12:0] l, bit pe, bit pv);
        @(negedge clk);
        wr_pid = p; wr_seg = s;
        wr_base_en = be; wr_base = b;
        wr_len_en = le; wr_len = l;
        wr_pres_en = pe; wr_pres = pv;
        @(negedge clk);
        wr_base_en = 1'b0; wr_len_en = 1'b0; wr_pres_en = 1'b0;
    endtask

    task automatic look(string tag, logic [1:0] p, logic [1:0] s, logic [11:0] o,
                        int kind, logic [15:0] epa);
        @(negedge clk);
        req_valid = 1'b1; req_pid = p; req_seg = s; req_off = o;
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp(tag, 1'b1, kind, epa);
    endtask

    task automatic t_reset;
        expect_rsp("R1 reset outputs", 1'b0, K_OK, 16'd0);
        look("R1 untouched entry misses", 2'd2, 2'd0, 12'd0, K_MISS, 16'd0);
        @(negedge clk);
        expect_rsp("R2 no request no response", 1'b0, K_OK, 16'd0);
    endtask

    task automatic t_load_tables;
        // process 0
        put(2'd0, 2'd0, 1, 16'd200, 1, 13'd150, 1, 1);
        put(2'd0, 2'd1, 1, 16'd400, 1, 13'd120, 1, 1);
        put(2'd0, 2'd2, 1, 16'd600, 1, 13'd80,  1, 1);
        // process 1
        put(2'd1, 2'd0, 1, 16'd350, 1, 13'd44,  1, 1);
        put(2'd1, 2'd1, 1, 16'd0,   1, 13'd150, 1, 1);
        put(2'd1, 2'd2, 1, 16'd400, 1, 13'd120, 1, 1);
    endtask

    task automatic t_translate;
        look("R3 pid1 seg0 off23", 2'd1, 2'd0, 12'd23, K_OK, 16'd373);
        look("R7 pid0 seg1 shared", 2'd0, 2'd1, 12'd23, K_OK, 16'd423);
        look("R7 pid1 seg2 shared", 2'd1, 2'd2, 12'd23, K_OK, 16'd423);
        look("R7 same seg other pid", 2'd0, 2'd0, 12'd23, K_OK, 16'd223);
        put(2'd3, 2'd3, 1, 16'hFFF0, 1, 13'd100, 1, 1);
        look("R3 wrap modulo", 2'd3, 2'd3, 12'h020, K_OK, 16'h0010);
    endtask

    task automatic t_bounds;
        look("R5 last offset ok", 2'd0, 2'd2, 12'd79, K_OK, 16'd679);
        look("R5 offset equals length", 2'd0, 2'd2, 12'd80, K_BND, 16'd0);
        look("R5 offset past length", 2'd1, 2'd0, 12'd300, K_BND, 16'd0);
        put(2'd3, 2'd1, 1, 16'd10, 1, 13'd0, 1, 1);
        look("R5 zero length", 2'd3, 2'd1, 12'd0, K_BND, 16'd0);
    endtask

    task automatic t_miss_priority;
        put(2'd3, 2'd2, 1, 16'd10, 1, 13'd0, 1, 0);
        look("R4 miss over bounds", 2'd3, 2'd2, 12'd5, K_MISS, 16'd0);
    endtask

    task automatic t_field_writes;
        put(2'd0, 2'd0, 1, 16'd1000, 0, 13'd0, 0, 0);
        look("R8 base moved", 2'd0, 2'd0, 12'd149, K_OK, 16'd1149);
        look("R8 length kept", 2'd0, 2'd0, 12'd150, K_BND, 16'd0);
        put(2'd0, 2'd0, 0, 16'd0, 1, 13'd200, 0, 0);
        look("R9 length grown", 2'd0, 2'd0, 12'd160, K_OK, 16'd1160);
        put(2'd1, 2'd1, 0, 16'd0, 0, 13'd0, 1, 0);
        look("R11 cleared residency", 2'd1, 2'd1, 12'd5, K_MISS, 16'd0);
        put(2'd1, 2'd1, 0, 16'd0, 0, 13'd0, 1, 1);
        look("R11 restored keeps base", 2'd1, 2'd1, 12'd5, K_OK, 16'd5);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        req_valid = 1'b1; req_pid = 2'd0; req_seg = 2'd1; req_off = 12'd0;
        wr_pid = 2'd0; wr_seg = 2'd1; wr_base_en = 1'b1; wr_base = 16'd900;
        @(negedge clk);
        wr_base_en = 1'b0;
        expect_rsp("R10 current lookup sees old base", 1'b1, K_OK, 16'd400);
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R10 next lookup sees new base", 1'b1, K_OK, 16'd900);
        @(negedge clk);
        expect_rsp("R2 response ends", 1'b0, K_OK, 16'd0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre: begin
            expect_rsp("R1 outputs in reset", 1'b0, K_OK, 16'd0);
        end
        rst_n = 1'b1;
        t_reset;
        t_load_tables;
        t_translate;
        t_bounds;
        t_miss_priority;
        t_field_writes;
        t_same_cycle;
        finish_run;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run;
    end
endmodule